// File: doc/BRIEF.md
# Watchdog Reset Gate and Cause Log

This block sits between per-cluster watchdog timers and the chip's reset controller. For every processor cluster it drives a counter-run enable toward that cluster's watchdog. It decides whether the watchdog's reset request may reach the system. It also keeps a sticky record of which cluster's watchdog caused the last reset, so that software can read the cause after reboot. The watchdog counters themselves live elsewhere.

Three things gate a reset request. The first is a per-cluster mask bit, whose meaning is fixed per cluster by a parameter. With the plain polarity a set bit blocks the request. With the inverted polarity a set bit lets the request through. The second is an auto-suppress bit: while it is set, the request is blocked for as long as that cluster's processor is itself held in reset. Requests that pass are ORed together and registered once to form a glitch-free system reset. Software reaches four registers through a simple write-strobe bus with combinational read data. Only a power-on reset clears the block.

Top module: `wdg_reset_gate`

## Requirements
- R1: After power-on reset every register reads zero, `cnt_en` is all low and `sys_rst` is low.
- R2: The counter-enable register at offset 0x420 holds cluster 0's bit at position 7 and cluster 1's bit at position 8. `cnt_en[i]` equals the stored bit from the cycle after the write, and it does not change without a write to that offset.
- R3: Cluster 0 uses plain polarity. With its mask bit (position 2 of offsets 0x40C) set, its watchdog request is blocked. With the bit clear, the request passes.
- R4: Cluster 1 uses inverted polarity. With its mask bit (position 3 of offset 0x40C) set, its request passes. With the bit clear, the request is blocked.
- R5: The auto-suppress register at offset 0x408 uses the same bit positions as the mask (2 for cluster 0, 3 for cluster 1). When a cluster's bit is set and its `cpu_in_rst` input is high, that cluster's request is blocked. When `cpu_in_rst` is low, the bit has no effect.
- R6: `sys_rst` is high exactly one clock after a cycle in which at least one request passed its gating, and low otherwise.
- R7: The reset-cause register at offset 0x404 holds cluster 0's bit at position 24 and cluster 1's bit at position 23. A cluster's bit is set on the same edge that its passing request raises `sys_rst`. Once set, it stays set until it is cleared.
- R8: Writing 1 to a cause bit clears that bit, and writing 0 leaves it unchanged. If a new passing request arrives in the same cycle as the clear, the bit stays set.
- R9: Reads of any offset other than 0x404, 0x408, 0x40C and 0x420 return zero, and writes to such offsets change no register. Bits outside the listed positions read zero and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Register byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| wd_rst_req | input | NUM_CL | Reset request from each cluster's watchdog |
| cpu_in_rst | input | NUM_CL | High while that cluster's processor is held in reset |
| cnt_en | output | NUM_CL | Counter-run enable to each cluster's watchdog |
| sys_rst | output | 1 | Registered system reset request |

## Verification
The assertions assume the bus inputs, `wd_rst_req` and `cpu_in_rst` are known values whenever `por_n` is high, and change only away from the rising clock edge. They also assume no other agent resets this block while it is counting. The stimulus drives every input on the falling edge. Writes and random requests are drawn only after reset has been released. The random mix steers addresses onto the four live offsets and two dead ones. It also pairs cause-clear writes with fresh requests, so that the set-over-clear case occurs often.

// File: rtl/wdg_gate_pkg.sv
package wdg_gate_pkg;

    localparam int REG_ADDR_W = 12;

    // Offsets decoded by the register block
    localparam logic [REG_ADDR_W-1:0] OFS_CAUSE = 12'h404;
    localparam logic [REG_ADDR_W-1:0] OFS_AUTO  = 12'h408;
    localparam logic [REG_ADDR_W-1:0] OFS_MASK  = 12'h40C;
    localparam logic [REG_ADDR_W-1:0] OFS_RUN   = 12'h420;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_AUTO,
        SEL_MASK,
        SEL_RUN
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [REG_ADDR_W-1:0] a);
        case (a)
            OFS_CAUSE: return SEL_CAUSE;
            OFS_AUTO:  return SEL_AUTO;
            OFS_MASK:  return SEL_MASK;
            OFS_RUN:   return SEL_RUN;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdg_gate_lane.sv
// Per-cluster gating of one watchdog reset request.
module wdg_gate_lane #(
    parameter bit INV_POL = 1'b0
) (
    input  logic req,
    input  logic cpu_rst,
    input  logic mask_bit,
    input  logic auto_bit,
    output logic pass
);
    logic allow;

    generate
        if (INV_POL) begin : g_inv
            assign allow = mask_bit;
        end else begin : g_plain
            assign allow = ~mask_bit;
        end
    endgenerate

    assign pass = req & allow & ~(auto_bit & cpu_rst);

    always_comb begin
        AST_NO_REQ_NO_PASS: assert (req || !pass);                 // R6
        AST_AUTO_BLOCKS: assert (!(auto_bit && cpu_rst) || !pass); // R5
    end

endmodule

// File: rtl/wdg_gate_regs.sv
// Register state, write decode, read mux and registered reset output.
module wdg_gate_regs
    import wdg_gate_pkg::*;
#(
    parameter int                      NUM_CL   = 2,
    parameter int                      DATA_W   = 32,
    parameter int                      POS_W    = $clog2(DATA_W),
    parameter logic [NUM_CL*POS_W-1:0] CAUSE_POS = '0,
    parameter logic [NUM_CL*POS_W-1:0] MASK_POS  = '0,
    parameter logic [NUM_CL*POS_W-1:0] RUN_POS   = '0
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_CL-1:0]     pass,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_CL-1:0]     mask_q,
    output logic [NUM_CL-1:0]     auto_q,
    output logic [NUM_CL-1:0]     run_q,
    output logic                  sys_rst_q
);
    typedef struct packed {
        logic [NUM_CL-1:0] mask;
        logic [NUM_CL-1:0] autod;
        logic [NUM_CL-1:0] run;
        logic [NUM_CL-1:0] cause;
        logic              sysr;
    } state_t;

    state_t            st_d, st_q;
    reg_sel_e          sel;
    logic [NUM_CL-1:0] w_mask, w_run, w_cause, clr;

    // Pick the per-cluster bits out of the write data
    always_comb begin
        sel = decode_ofs(addr);
        for (int i = 0; i < NUM_CL; i++) begin
            w_mask[i]  = wdata[MASK_POS[i*POS_W +: POS_W]];
            w_run[i]   = wdata[RUN_POS[i*POS_W +: POS_W]];
            w_cause[i] = wdata[CAUSE_POS[i*POS_W +: POS_W]];
        end
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr) begin
            case (sel)
                SEL_MASK:  st_d.mask  = w_mask;
                SEL_AUTO:  st_d.autod = w_mask;
                SEL_RUN:   st_d.run   = w_run;
                SEL_CAUSE: clr        = w_cause;
                default:   ;
            endcase
        end
        // a fresh passing request wins over a write-one clear
        st_d.cause = (st_q.cause & ~clr) | pass;
        st_d.sysr  = |pass;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux: unlisted offsets and unused bits read zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CL; i++) begin
            case (sel)
                SEL_CAUSE: rdata[CAUSE_POS[i*POS_W +: POS_W]] = st_q.cause[i];
                SEL_AUTO:  rdata[MASK_POS[i*POS_W +: POS_W]]  = st_q.autod[i];
                SEL_MASK:  rdata[MASK_POS[i*POS_W +: POS_W]]  = st_q.mask[i];
                SEL_RUN:   rdata[RUN_POS[i*POS_W +: POS_W]]   = st_q.run[i];
                default:   ;
            endcase
        end
    end

    assign mask_q    = st_q.mask;
    assign auto_q    = st_q.autod;
    assign run_q     = st_q.run;
    assign sys_rst_q = st_q.sysr;

    AST_RST_LOGGED: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_q |-> (|st_q.cause));                                          // R7
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !(wr && sel == SEL_CAUSE) |=> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause))); // R8
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !(wr && sel == SEL_RUN) |=> $stable(st_q.run));                        // R2
    AST_PASS_RAISES: assert property (@(posedge clk) disable iff (!por_n)
        (|pass) |=> sys_rst_q);                                                // R6

endmodule

// File: rtl/wdg_reset_gate.sv
// Top: watchdog reset gating, counter-run enables and reset-cause log.
module wdg_reset_gate
    import wdg_gate_pkg::*;
#(
    parameter int                      NUM_CL    = 2,
    parameter int                      DATA_W    = 32,
    parameter int                      POS_W     = $clog2(DATA_W),
    parameter logic [NUM_CL-1:0]       MASK_INV  = 2'b10,
    parameter logic [NUM_CL*POS_W-1:0] CAUSE_POS = {5'd23, 5'd24},
    parameter logic [NUM_CL*POS_W-1:0] MASK_POS  = {5'd3, 5'd2},
    parameter logic [NUM_CL*POS_W-1:0] RUN_POS   = {5'd8, 5'd7}
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_CL-1:0]     wd_rst_req,
    input  logic [NUM_CL-1:0]     cpu_in_rst,
    output logic [NUM_CL-1:0]     cnt_en,
    output logic                  sys_rst
);
    logic [NUM_CL-1:0] pass, mask_q, auto_q;

    generate
        for (genvar i = 0; i < NUM_CL; i++) begin : g_lane
            wdg_gate_lane #(.INV_POL(MASK_INV[i])) u_lane (
                .req      (wd_rst_req[i]),
                .cpu_rst  (cpu_in_rst[i]),
                .mask_bit (mask_q[i]),
                .auto_bit (auto_q[i]),
                .pass     (pass[i])
            );
        end
    endgenerate

    wdg_gate_regs #(
        .NUM_CL    (NUM_CL),
        .DATA_W    (DATA_W),
        .POS_W     (POS_W),
        .CAUSE_POS (CAUSE_POS),
        .MASK_POS  (MASK_POS),
        .RUN_POS   (RUN_POS)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pass      (pass),
        .rdata     (bus_rdata),
        .mask_q    (mask_q),
        .auto_q    (auto_q),
        .run_q     (cnt_en),
        .sys_rst_q (sys_rst)
    );

    AST_IDLE_NO_RST: assert property (@(posedge clk) disable iff (!por_n)
        (wd_rst_req == '0) |=> !sys_rst);                                      // R6

endmodule

// File: tb/tb_wdg_reset_gate.sv
module tb_wdg_reset_gate;
    localparam logic [11:0] A_CAUSE = 12'h404;
    localparam logic [11:0] A_AUTO  = 12'h408;
    localparam logic [11:0] A_MASK  = 12'h40C;
    localparam logic [11:0] A_RUN   = 12'h420;
    localparam logic [11:0] A_DEAD0 = 12'h410;
    localparam logic [11:0] A_DEAD1 = 12'h000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  wd_rst_req = '0;
    logic [1:0]  cpu_in_rst = '0;
    logic [1:0]  cnt_en;
    logic        sys_rst;

    int n_chk = 0;
    int n_fail = 0;

    // model state
    logic [1:0] m_mask = '0, m_auto = '0, m_run = '0, m_cause = '0;
    logic       m_sys = 1'b0;

    always #5 clk = ~clk;

    wdg_reset_gate dut (
        .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req),
        .cpu_in_rst(cpu_in_rst), .cnt_en(cnt_en), .sys_rst(sys_rst)
    );

    function automatic logic [1:0] gate(input logic [1:0] rq, input logic [1:0] cr,
                                        input logic [1:0] mk, input logic [1:0] au);
        logic [1:0] allow;
        allow[0] = ~mk[0];  // plain polarity
        allow[1] =  mk[1];  // inverted polarity
        return rq & allow & ~(au & cr);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            A_CAUSE: begin r[24] = m_cause[0]; r[23] = m_cause[1]; end
            A_AUTO:  begin r[2] = m_auto[0]; r[3] = m_auto[1]; end
            A_MASK:  begin r[2] = m_mask[0]; r[3] = m_mask[1]; end
            A_RUN:   begin r[7] = m_run[0]; r[8] = m_run[1]; end
            default: ;
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive after falling edge, check after the next falling edge
    task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [1:0] rq, input logic [1:0] cr);
        logic [1:0] pv;
        pv = gate(rq, cr, m_mask, m_auto);
        bus_wr = wr; bus_addr = a; bus_wdata = d; wd_rst_req = rq; cpu_in_rst = cr;
        @(posedge clk);
        if (wr) begin
            case (a)
                A_MASK:  m_mask = {d[3], d[2]};
                A_AUTO:  m_auto = {d[3], d[2]};
                A_RUN:   m_run  = {d[8], d[7]};
                A_CAUSE: m_cause = m_cause & ~{d[23], d[24]};
                default: ;
            endcase
        end
        m_cause = m_cause | pv;
        m_sys   = |pv;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 sys_rst", {31'd0, sys_rst}, {31'd0, m_sys});
        chk("R2 cnt_en", {30'd0, cnt_en}, {30'd0, m_run});
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..R9 run hung actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [11:0] addrs [6];
        void'($urandom(32'h5EED));
        addrs[0] = A_CAUSE; addrs[1] = A_AUTO; addrs[2] = A_MASK;
        addrs[3] = A_RUN;   addrs[4] = A_DEAD0; addrs[5] = A_DEAD1;

        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 sys_rst", {31'd0, sys_rst}, 32'd0);
        chk("R1 cnt_en", {30'd0, cnt_en}, 32'd0);
        rd("R1 cause", A_CAUSE); rd("R1 auto", A_AUTO);
        rd("R1 mask", A_MASK);   rd("R1 run", A_RUN);

        // R2: counter enables
        step(1'b1, A_RUN, 32'h0000_0080, 2'b00, 2'b00);
        rd("R2 run rd", A_RUN);
        step(1'b1, A_RUN, 32'h0000_0100, 2'b00, 2'b00);
        step(1'b0, A_RUN, 32'hFFFF_FFFF, 2'b00, 2'b00);
        rd("R2 run rd2", A_RUN);

        // R3: cluster 0 plain polarity, mask clear passes
        step(1'b0, A_DEAD1, '0, 2'b01, 2'b00);
        rd("R7 cause c0", A_CAUSE);
        step(1'b1, A_CAUSE, 32'h0100_0000, 2'b00, 2'b00);
        rd("R8 cleared", A_CAUSE);
        step(1'b1, A_MASK, 32'h0000_0004, 2'b00, 2'b00);
        step(1'b0, A_DEAD1, '0, 2'b01, 2'b00);
        rd("R3 blocked no cause", A_CAUSE);

        // R4: cluster 1 inverted polarity
        step(1'b1, A_MASK, 32'h0000_0000, 2'b00, 2'b00);
        step(1'b0, A_DEAD1, '0, 2'b10, 2'b00);
        rd("R4 blocked", A_CAUSE);
        step(1'b1, A_MASK, 32'h0000_0008, 2'b00, 2'b00);
        step(1'b0, A_DEAD1, '0, 2'b10, 2'b00);
        rd("R4 passes", A_CAUSE);

        // R5: auto-suppress
        step(1'b1, A_AUTO, 32'h0000_000C, 2'b00, 2'b00);
        step(1'b1, A_CAUSE, 32'hFFFF_FFFF, 2'b00, 2'b00);
        step(1'b0, A_DEAD1, '0, 2'b11, 2'b11);
        rd("R5 suppressed", A_CAUSE);
        step(1'b0, A_DEAD1, '0, 2'b10, 2'b00);
        rd("R5 cpu running", A_CAUSE);

        // R8: set wins over clear in the same cycle
        step(1'b1, A_CAUSE, 32'h0080_0000, 2'b10, 2'b00);
        rd("R8 set wins", A_CAUSE);

        // R9: dead offsets and unused bits
        step(1'b1, A_DEAD0, 32'hFFFF_FFFF, 2'b00, 2'b00);
        rd("R9 dead read", A_DEAD0);
        rd("R9 mask intact", A_MASK);
        rd("R9 run intact", A_RUN);
        step(1'b1, A_MASK, 32'hFFFF_FFFF, 2'b00, 2'b00);
        rd("R9 unused bits", A_MASK);

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic        w;
            logic [11:0] a;
            logic [31:0] d;
            w = ($urandom % 3) == 0;
            a = addrs[$urandom % 6];
            d = $urandom;
            step(w, a, d, 2'($urandom), 2'($urandom));
            rd("R9 R7 random read", addrs[$urandom % 6]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule